// File: doc/BRIEF.md
# APB-to-OPB Transaction Bridge

This block is a 4 KB APB slave register file through which a host issues single accesses on an on-chip peripheral bus (OPB). Two independent channels each hold a select flag, a direction, a size code, a target address and write data. A write of any value to the shared launch register starts one access on whichever channel has its select flag set. The two channels share one valid/ready request port, and the port carries the channel number with each request.

The access is held on the request port until the fabric accepts it. The bridge then waits for a response that carries read data and an error flag. A clean completion sets that channel's sticky acknowledge flag, which drives the interrupt output. A clean read also stores its data, right-aligned and zero-extended, in the channel's capture register. A response with the error flag leaves both untouched. Sub-word accesses use little-endian byte lanes chosen by the two low address bits. A window-base register, a control register and six endian-configuration registers are kept as plain storage for software.

Top module: `opb_xact_bridge`

## Requirements
- R1: After reset, offset 0x00 reads 0x000000A1, and 0x4C/0x50/0x54/0x58/0x5C/0x60 read 0x0044EEE4, 0x0055AAFF, 0x00117717, 0xFFAA5500, 0x0044EEE4 and 0x00117717. Every other implemented register reads 0.
- R2: Control (0x08), window base (0x0C), the channel registers and the endian registers read back what was written. Offsets that are not implemented, or are not word-aligned, read 0 and ignore writes. The version register (0x00) and the capture registers (0x84, 0x90) ignore writes.
- R3: A write to 0x04 with exactly one select flag set (bit 0 of 0x10 for channel 0, or of 0x28 for channel 1) raises opb_req_valid. The request shows that channel on opb_req_chan and its address register (0x1C or 0x34) on opb_req_addr. opb_req_rd is set when bit 0 of the mode register (0x14 or 0x2C) is 1, and clear when it is 0 (a write).
- R4: A launch write with neither select flag set, or with both set, issues no request.
- R5: The size register (0x18 or 0x30) holds the byte count minus one: 0 is a byte, 1 a halfword, 3 a word. Any other value, including 2, makes the launch write issue no request.
- R6: A byte access enables lane addr[1:0] and places data bits 7:0 on that lane. A halfword enables lanes 1:0 when addr[1] is 0 and lanes 3:2 when addr[1] is 1, and places data bits 15:0 there. A word enables all four lanes with the data unchanged. Write data comes from 0x20 or 0x38.
- R7: On a clean read completion, the capture register (0x84 for channel 0, 0x90 for channel 1) takes the addressed lanes of opb_rsp_rdata, right-aligned and zero-extended.
- R8: A clean completion sets status bit 16 (channel 0) or bit 17 (channel 1) of 0x48. The bit stays set until software writes a 1 to it, and writing 1 to the other bit leaves it alone. irq is high exactly while either bit is set.
- R9: A completion with opb_rsp_err set changes neither the status bits nor the capture register.
- R10: Bit 31 of 0x04 reads 1 from the launch until the response is taken. Every other bit of 0x04 reads 0. A launch write while bit 31 is 1 is ignored.
- R11: While opb_req_valid is high and opb_req_ready is low, the request stays valid and all request fields stay unchanged.
- R12: opb_rsp_valid is only taken after the request has been accepted. apb_ready is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| apb_sel | input | 1 | APB select |
| apb_enable | input | 1 | APB access phase |
| apb_write | input | 1 | APB write (1) or read (0) |
| apb_addr | input | 12 | APB byte offset |
| apb_wdata | input | 32 | APB write data |
| apb_rdata | output | 32 | APB read data |
| apb_ready | output | 1 | APB ready, always 1 |
| irq | output | 1 | High while any acknowledge flag is set |
| opb_req_valid | output | 1 | Request valid |
| opb_req_ready | input | 1 | Request accepted by the fabric |
| opb_req_chan | output | 1 | Channel that issued the request |
| opb_req_rd | output | 1 | 1 for a read, 0 for a write |
| opb_req_addr | output | 32 | Target byte address |
| opb_req_be | output | 4 | Byte-lane enables |
| opb_req_wdata | output | 32 | Lane-placed write data |
| opb_rsp_valid | input | 1 | Response valid |
| opb_rsp_err | input | 1 | Response reports a bus error |
| opb_rsp_rdata | input | 32 | Response read data |

## Verification
Some properties are checked by the assertions on every cycle. A request must stay frozen while it is stalled. It may only appear after a launch write with a single select flag. Its lane enables must cover one, two or four bytes. An acknowledge flag may only rise on a clean completion for its own channel. A capture register may only change on a clean read completion for its channel.

Other behaviour can only be shown by the bench's scenarios. The sweep over channel, direction, size code and low address bits compares lane enables, lane-placed data and captured read data against values worked out arithmetically. The bench also covers reset values, readback of the storage registers, the rejected launches, the busy flag, error completions and clearing each status bit on its own.

// File: rtl/apb_opb_pkg.sv
// Shared constants, register offsets and transaction type for the
// APB-to-OPB bridge. Assumes exactly two channels; the per-channel
// offsets are computed from a base and a stride.
package apb_opb_pkg;
    localparam int NUM_CHAN  = 2;
    localparam int CHAN_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
    localparam int CNT_W     = $clog2(NUM_CHAN + 1);
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int LANES     = DATA_W / 8;

    // Fixed offsets
    localparam logic [ADDR_W-1:0] A_VERSION = 12'h000;
    localparam logic [ADDR_W-1:0] A_LAUNCH  = 12'h004;
    localparam logic [ADDR_W-1:0] A_CONTROL = 12'h008;
    localparam logic [ADDR_W-1:0] A_WINDOW  = 12'h00C;
    localparam logic [ADDR_W-1:0] A_STATUS  = 12'h048;

    // Per-channel register group: base + chan * stride + field
    localparam int CH_BASE   = 'h010;
    localparam int CH_STRIDE = 'h018;
    localparam int F_SEL     = 'h0;
    localparam int F_MODE    = 'h4;
    localparam int F_SIZE    = 'h8;
    localparam int F_ADDR    = 'hC;
    localparam int F_WDAT    = 'h10;

    // Endian storage and read capture
    localparam int WRWORD_BASE = 'h04C;
    localparam int WRBYTE_BASE = 'h050;
    localparam int WR_STRIDE   = 'h008;
    localparam int RDBYTE_BASE = 'h05C;
    localparam int RDBYTE_STR  = 'h004;
    localparam int CAP_BASE    = 'h084;
    localparam int CAP_STRIDE  = 'h00C;

    localparam int ACK_LSB  = 16;
    localparam int BUSY_BIT = 31;
    localparam logic [DATA_W-1:0] VERSION_VAL = 32'h0000_00A1;

    // Size codes (byte count minus one)
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd3;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              rd;
        logic [1:0]        size;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } opb_xact_t;

    function automatic logic [ADDR_W-1:0] ch_ofs(input int c, input int field);
        return ADDR_W'(CH_BASE + c * CH_STRIDE + field);
    endfunction

    function automatic logic [DATA_W-1:0] rst_wr_word(input int c);
        return (c == 0) ? 32'h0044_EEE4 : 32'h0011_7717;
    endfunction

    function automatic logic [DATA_W-1:0] rst_wr_byte(input int c);
        return (c == 0) ? 32'h0055_AAFF : 32'hFFAA_5500;
    endfunction

    function automatic logic [DATA_W-1:0] rst_rd_byte(input int c);
        return (c == 0) ? 32'h0044_EEE4 : 32'h0011_7717;
    endfunction
endpackage

// File: rtl/opb_lane_map.sv
// Byte-lane steering for one access: places write data on lanes chosen
// by size and low address bits, and right-aligns read data from those
// lanes. Purely combinational. Assumes the size code is byte, half or
// word; halfword placement uses addr[1] only.
module opb_lane_map
    import apb_opb_pkg::*;
(
    input  logic [1:0]        size_i,
    input  logic [1:0]        addr_lo_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rdata_raw_i,
    output logic [LANES-1:0]  be_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [4:0] byte_shift;
    assign byte_shift = {addr_lo_i, 3'b000};

    // Select lanes and steer data in both directions
    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                be_o    = LANES'(1) << addr_lo_i;
                wdata_o = {24'd0, wdata_i[7:0]} << byte_shift;
                rdata_o = {24'd0, 8'(rdata_raw_i >> byte_shift)};
            end
            SZ_HALF: begin
                be_o    = addr_lo_i[1] ? 4'b1100 : 4'b0011;
                wdata_o = addr_lo_i[1] ? {wdata_i[15:0], 16'd0} : {16'd0, wdata_i[15:0]};
                rdata_o = {16'd0, addr_lo_i[1] ? rdata_raw_i[31:16] : rdata_raw_i[15:0]};
            end
            default: begin
                be_o    = '1;
                wdata_o = wdata_i;
                rdata_o = rdata_raw_i;
            end
        endcase
    end
endmodule

// File: rtl/opb_launch.sv
// Launch controller: validates a launch strobe against the channel
// selects and size codes, snapshots the chosen channel's settings, holds
// the request until accepted and waits for the response. Assumes the
// response never arrives before the request is accepted.
module opb_launch
    import apb_opb_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           trig_i,
    input  logic [NUM_CHAN-1:0]            sel_i,
    input  logic [NUM_CHAN-1:0]            rd_i,
    input  logic [NUM_CHAN-1:0][DATA_W-1:0] size_i,
    input  logic [NUM_CHAN-1:0][DATA_W-1:0] addr_i,
    input  logic [NUM_CHAN-1:0][DATA_W-1:0] wdat_i,
    output logic                           req_valid_o,
    input  logic                           req_ready_i,
    input  logic                           rsp_valid_i,
    input  logic                           rsp_err_i,
    output opb_xact_t                      xact_o,
    output logic                           busy_o,
    output logic                           done_o,
    output logic                           done_ok_o
);
    typedef enum logic [1:0] { ST_IDLE, ST_REQ, ST_WAIT } lstate_t;

    lstate_t           state_q;
    opb_xact_t         xact_q;
    logic [CNT_W-1:0]  sel_cnt;
    logic [CHAN_W-1:0] pick;
    logic [DATA_W-1:0] pick_size;
    logic              size_ok;
    logic              launch;

    // Count selected channels and find the chosen one
    always_comb begin
        sel_cnt = '0;
        pick    = '0;
        for (int c = 0; c < NUM_CHAN; c++) begin
            if (sel_i[c]) begin
                sel_cnt = sel_cnt + CNT_W'(1);
                pick    = CHAN_W'(c);
            end
        end
    end

    // Accept only byte, halfword and word size codes
    always_comb begin
        pick_size = size_i[pick];
        size_ok   = (pick_size == DATA_W'(SZ_BYTE)) ||
                    (pick_size == DATA_W'(SZ_HALF)) ||
                    (pick_size == DATA_W'(SZ_WORD));
    end

    assign launch = trig_i && (state_q == ST_IDLE) && (sel_cnt == CNT_W'(1)) && size_ok;

    // Sequence one access: idle, request, wait for response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            xact_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (launch) begin
                    state_q      <= ST_REQ;
                    xact_q.chan  <= pick;
                    xact_q.rd    <= rd_i[pick];
                    xact_q.size  <= pick_size[1:0];
                    xact_q.addr  <= addr_i[pick];
                    xact_q.wdata <= wdat_i[pick];
                end
                ST_REQ:  if (req_ready_i) state_q <= ST_WAIT;
                ST_WAIT: if (rsp_valid_i) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_valid_o = (state_q == ST_REQ);
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = (state_q == ST_WAIT) && rsp_valid_i;
    assign done_ok_o   = !rsp_err_i;
    assign xact_o      = xact_q;

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(xact_q)));

    assert_launch_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) |-> $past(trig_i));

    assert_single_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid_o) |-> $past($countones(sel_i) == 1));

    assert_rsp_after_accept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));
endmodule

// File: rtl/opb_bridge_regs.sv
// Register file of the bridge: decodes whole-word APB accesses,
// stores per-channel settings and endian configuration, captures read
// data and keeps the sticky write-one-to-clear acknowledge flags.
// Assumes one access per cycle with a fixed zero-wait-state response.
module opb_bridge_regs
    import apb_opb_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            acc_wr_i,
    input  logic [ADDR_W-1:0]               acc_addr_i,
    input  logic [DATA_W-1:0]               acc_wdata_i,
    output logic [DATA_W-1:0]               acc_rdata_o,
    output logic                            trig_o,
    output logic [NUM_CHAN-1:0]             sel_o,
    output logic [NUM_CHAN-1:0]             rd_o,
    output logic [NUM_CHAN-1:0][DATA_W-1:0] size_o,
    output logic [NUM_CHAN-1:0][DATA_W-1:0] addr_o,
    output logic [NUM_CHAN-1:0][DATA_W-1:0] wdat_o,
    input  logic                            busy_i,
    input  logic                            done_i,
    input  logic                            done_ok_i,
    input  logic [CHAN_W-1:0]               done_chan_i,
    input  logic                            done_rd_i,
    input  logic [DATA_W-1:0]               done_data_i,
    output logic                            irq_o
);
    logic [DATA_W-1:0]               ctl_q, win_q;
    logic [NUM_CHAN-1:0][DATA_W-1:0] sel_q, mode_q, size_q, addr_q, wdat_q;
    logic [NUM_CHAN-1:0][DATA_W-1:0] wrword_q, wrbyte_q, rdbyte_q, cap_q;
    logic [NUM_CHAN-1:0]             ack_q;

    // Register writes, read-data capture and acknowledge flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            win_q  <= '0;
            sel_q  <= '0;
            mode_q <= '0;
            size_q <= '0;
            addr_q <= '0;
            wdat_q <= '0;
            cap_q  <= '0;
            ack_q  <= '0;
            for (int c = 0; c < NUM_CHAN; c++) begin
                wrword_q[c] <= rst_wr_word(c);
                wrbyte_q[c] <= rst_wr_byte(c);
                rdbyte_q[c] <= rst_rd_byte(c);
            end
        end else begin
            if (acc_wr_i && acc_addr_i == A_CONTROL) ctl_q <= acc_wdata_i;
            if (acc_wr_i && acc_addr_i == A_WINDOW)  win_q <= acc_wdata_i;
            for (int c = 0; c < NUM_CHAN; c++) begin
                if (acc_wr_i) begin
                    if (acc_addr_i == ch_ofs(c, F_SEL))  sel_q[c]  <= acc_wdata_i;
                    if (acc_addr_i == ch_ofs(c, F_MODE)) mode_q[c] <= acc_wdata_i;
                    if (acc_addr_i == ch_ofs(c, F_SIZE)) size_q[c] <= acc_wdata_i;
                    if (acc_addr_i == ch_ofs(c, F_ADDR)) addr_q[c] <= acc_wdata_i;
                    if (acc_addr_i == ch_ofs(c, F_WDAT)) wdat_q[c] <= acc_wdata_i;
                    if (acc_addr_i == ADDR_W'(WRWORD_BASE + c * WR_STRIDE)) wrword_q[c] <= acc_wdata_i;
                    if (acc_addr_i == ADDR_W'(WRBYTE_BASE + c * WR_STRIDE)) wrbyte_q[c] <= acc_wdata_i;
                    if (acc_addr_i == ADDR_W'(RDBYTE_BASE + c * RDBYTE_STR)) rdbyte_q[c] <= acc_wdata_i;
                end
                if (done_i && done_ok_i && done_chan_i == CHAN_W'(c)) begin
                    ack_q[c] <= 1'b1;
                    if (done_rd_i) cap_q[c] <= done_data_i;
                end else if (acc_wr_i && acc_addr_i == A_STATUS && acc_wdata_i[ACK_LSB + c]) begin
                    ack_q[c] <= 1'b0;
                end
            end
        end
    end

    // Read multiplexer; unmatched offsets return zero
    always_comb begin
        acc_rdata_o = '0;
        unique case (acc_addr_i)
            A_VERSION: acc_rdata_o = VERSION_VAL;
            A_LAUNCH:  acc_rdata_o = DATA_W'(busy_i) << BUSY_BIT;
            A_CONTROL: acc_rdata_o = ctl_q;
            A_WINDOW:  acc_rdata_o = win_q;
            A_STATUS:  acc_rdata_o = DATA_W'(ack_q) << ACK_LSB;
            default:   acc_rdata_o = '0;
        endcase
        for (int c = 0; c < NUM_CHAN; c++) begin
            if (acc_addr_i == ch_ofs(c, F_SEL))  acc_rdata_o = sel_q[c];
            if (acc_addr_i == ch_ofs(c, F_MODE)) acc_rdata_o = mode_q[c];
            if (acc_addr_i == ch_ofs(c, F_SIZE)) acc_rdata_o = size_q[c];
            if (acc_addr_i == ch_ofs(c, F_ADDR)) acc_rdata_o = addr_q[c];
            if (acc_addr_i == ch_ofs(c, F_WDAT)) acc_rdata_o = wdat_q[c];
            if (acc_addr_i == ADDR_W'(WRWORD_BASE + c * WR_STRIDE))  acc_rdata_o = wrword_q[c];
            if (acc_addr_i == ADDR_W'(WRBYTE_BASE + c * WR_STRIDE))  acc_rdata_o = wrbyte_q[c];
            if (acc_addr_i == ADDR_W'(RDBYTE_BASE + c * RDBYTE_STR)) acc_rdata_o = rdbyte_q[c];
            if (acc_addr_i == ADDR_W'(CAP_BASE + c * CAP_STRIDE))    acc_rdata_o = cap_q[c];
        end
    end

    // Per-channel views for the launch controller
    always_comb begin
        for (int c = 0; c < NUM_CHAN; c++) begin
            sel_o[c] = sel_q[c][0];
            rd_o[c]  = mode_q[c][0];
        end
    end

    assign size_o = size_q;
    assign addr_o = addr_q;
    assign wdat_o = wdat_q;
    assign trig_o = acc_wr_i && (acc_addr_i == A_LAUNCH);
    assign irq_o  = |ack_q;

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan_chk
        assert_ack_on_success_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ack_q[c]) |-> $past(done_i && done_ok_i && done_chan_i == CHAN_W'(c)));

        assert_capture_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !(done_i && done_ok_i && done_rd_i && done_chan_i == CHAN_W'(c)) |=> $stable(cap_q[c]));

        assert_error_no_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (done_i && !done_ok_i && !ack_q[c]) |=> !ack_q[c]);
    end
endmodule

// File: rtl/opb_xact_bridge.sv
// Top of the APB-to-OPB transaction bridge: APB register access,
// launch controller and byte-lane steering joined onto one request
// port shared by both channels. Assumes zero-wait-state APB.
module opb_xact_bridge
    import apb_opb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apb_sel,
    input  logic              apb_enable,
    input  logic              apb_write,
    input  logic [11:0]       apb_addr,
    input  logic [31:0]       apb_wdata,
    output logic [31:0]       apb_rdata,
    output logic              apb_ready,
    output logic              irq,
    output logic              opb_req_valid,
    input  logic              opb_req_ready,
    output logic              opb_req_chan,
    output logic              opb_req_rd,
    output logic [31:0]       opb_req_addr,
    output logic [3:0]        opb_req_be,
    output logic [31:0]       opb_req_wdata,
    input  logic              opb_rsp_valid,
    input  logic              opb_rsp_err,
    input  logic [31:0]       opb_rsp_rdata
);
    logic                            acc_wr, trig, busy, done, done_ok;
    logic [NUM_CHAN-1:0]             ch_sel, ch_rd;
    logic [NUM_CHAN-1:0][DATA_W-1:0] ch_size, ch_addr, ch_wdat;
    opb_xact_t                       xact;
    logic [DATA_W-1:0]               rd_aligned;

    assign acc_wr    = apb_sel && apb_enable && apb_write;
    assign apb_ready = 1'b1;

    opb_bridge_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_wr_i    (acc_wr),
        .acc_addr_i  (apb_addr),
        .acc_wdata_i (apb_wdata),
        .acc_rdata_o (apb_rdata),
        .trig_o      (trig),
        .sel_o       (ch_sel),
        .rd_o        (ch_rd),
        .size_o      (ch_size),
        .addr_o      (ch_addr),
        .wdat_o      (ch_wdat),
        .busy_i      (busy),
        .done_i      (done),
        .done_ok_i   (done_ok),
        .done_chan_i (xact.chan),
        .done_rd_i   (xact.rd),
        .done_data_i (rd_aligned),
        .irq_o       (irq)
    );

    opb_launch u_launch (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_i      (trig),
        .sel_i       (ch_sel),
        .rd_i        (ch_rd),
        .size_i      (ch_size),
        .addr_i      (ch_addr),
        .wdat_i      (ch_wdat),
        .req_valid_o (opb_req_valid),
        .req_ready_i (opb_req_ready),
        .rsp_valid_i (opb_rsp_valid),
        .rsp_err_i   (opb_rsp_err),
        .xact_o      (xact),
        .busy_o      (busy),
        .done_o      (done),
        .done_ok_o   (done_ok)
    );

    opb_lane_map u_lanes (
        .size_i      (xact.size),
        .addr_lo_i   (xact.addr[1:0]),
        .wdata_i     (xact.wdata),
        .rdata_raw_i (opb_rsp_rdata),
        .be_o        (opb_req_be),
        .wdata_o     (opb_req_wdata),
        .rdata_o     (rd_aligned)
    );

    assign opb_req_chan = xact.chan;
    assign opb_req_rd   = xact.rd;
    assign opb_req_addr = xact.addr;

    assert_lane_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        opb_req_valid |-> ($countones(opb_req_be) == 1 || $countones(opb_req_be) == 2 ||
                           $countones(opb_req_be) == 4));

    assert_irq_follows_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(done && done_ok));
endmodule

// File: tb/opb_xact_bridge_tb_top.sv
// Self-checking bench: sweeps channel, direction, size and low address
// bits, plus reset, storage, rejection, busy and error scenarios.
module opb_xact_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        apb_sel = 1'b0, apb_enable = 1'b0, apb_write = 1'b0;
    logic [11:0] apb_addr = '0;
    logic [31:0] apb_wdata = '0;
    logic [31:0] apb_rdata;
    logic        apb_ready, irq;
    logic        opb_req_valid, opb_req_chan, opb_req_rd;
    logic        opb_req_ready = 1'b0;
    logic [31:0] opb_req_addr, opb_req_wdata;
    logic [3:0]  opb_req_be;
    logic        opb_rsp_valid = 1'b0, opb_rsp_err = 1'b0;
    logic [31:0] opb_rsp_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_cap [2];

    always #4 clk = ~clk;

    opb_xact_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .apb_sel(apb_sel), .apb_enable(apb_enable), .apb_write(apb_write),
        .apb_addr(apb_addr), .apb_wdata(apb_wdata), .apb_rdata(apb_rdata),
        .apb_ready(apb_ready), .irq(irq),
        .opb_req_valid(opb_req_valid), .opb_req_ready(opb_req_ready),
        .opb_req_chan(opb_req_chan), .opb_req_rd(opb_req_rd),
        .opb_req_addr(opb_req_addr), .opb_req_be(opb_req_be),
        .opb_req_wdata(opb_req_wdata), .opb_rsp_valid(opb_rsp_valid),
        .opb_rsp_err(opb_rsp_err), .opb_rsp_rdata(opb_rsp_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        apb_sel = 1'b1; apb_write = 1'b1; apb_addr = a; apb_wdata = d; apb_enable = 1'b0;
        @(negedge clk);
        apb_enable = 1'b1;
        @(negedge clk);
        apb_sel = 1'b0; apb_enable = 1'b0; apb_write = 1'b0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        apb_sel = 1'b1; apb_write = 1'b0; apb_addr = a; apb_enable = 1'b0;
        @(negedge clk);
        apb_enable = 1'b1;
        #1 d = apb_rdata;
        @(negedge clk);
        apb_sel = 1'b0; apb_enable = 1'b0;
    endtask

    function automatic logic [11:0] chb(input int c);
        return 12'(12'h010 + c * 12'h018);
    endfunction

    function automatic logic [11:0] capa(input int c);
        return 12'(12'h084 + c * 12'h00C);
    endfunction

    task automatic program_ch(input int c, input int rd, input logic [31:0] sz,
                              input logic [31:0] a, input logic [31:0] wd, input int selmask);
        apb_wr(chb(0), 32'(selmask & 1));
        apb_wr(chb(1), 32'((selmask >> 1) & 1));
        apb_wr(chb(c) + 12'h4, 32'(rd));
        apb_wr(chb(c) + 12'h8, sz);
        apb_wr(chb(c) + 12'hC, a);
        apb_wr(chb(c) + 12'h10, wd);
    endtask

    // A launch that must not reach the port
    task automatic expect_no_launch(input string tag, input int selmask, input logic [31:0] sz);
        logic [31:0] v;
        program_ch(0, 0, sz, 32'h8000_0040, 32'h1234_5678, selmask);
        apb_wr(12'h004, 32'h0);
        for (int i = 0; i < 4; i++) begin
            check({tag, " no request"}, 32'(opb_req_valid), 32'h0);
            @(negedge clk);
        end
        apb_rd(12'h004, v);
        check({tag, " idle busy bit R10"}, v, 32'h0);
    endtask

    // One full access with arithmetic expectations
    task automatic run_xact(input int c, input int rd, input int sz, input int lo,
                            input int err, input int delay, input int probe);
        logic [31:0] a, wd, rsp, v, exp_be, exp_wd, exp_rd;
        int w;
        a   = 32'h8000_1230 + 32'(lo) + 32'(c << 8);
        wd  = 32'h5A6B_7C8D + 32'(c * 16) + 32'(lo);
        rsp = 32'hD4C3_B2A1 + 32'(lo) * 32'h0101_0101 + 32'(c * 32'h100);
        if (sz == 0) begin
            exp_be = 32'(1 << lo);
            exp_wd = (wd & 32'hFF) << (8 * lo);
            exp_rd = (rsp >> (8 * lo)) & 32'hFF;
        end else if (sz == 1) begin
            exp_be = (lo >= 2) ? 32'hC : 32'h3;
            exp_wd = (wd & 32'hFFFF) << ((lo >= 2) ? 16 : 0);
            exp_rd = (rsp >> ((lo >= 2) ? 16 : 0)) & 32'hFFFF;
        end else begin
            exp_be = 32'hF;
            exp_wd = wd;
            exp_rd = rsp;
        end
        program_ch(c, rd, 32'(sz), a, wd, 1 << c);
        apb_wr(12'h004, 32'hFFFF_FFFF);
        w = 0;
        while (!opb_req_valid && w < 20) begin
            @(negedge clk);
            w++;
        end
        check("R3 request raised", 32'(opb_req_valid), 32'h1);
        check("R3 channel", 32'(opb_req_chan), 32'(c));
        check("R3 direction", 32'(opb_req_rd), 32'(rd));
        check("R3 address", opb_req_addr, a);
        check("R5 R6 lane enables", 32'(opb_req_be), exp_be);
        if (rd == 0) check("R6 lane data", opb_req_wdata, exp_wd);
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            check("R11 held valid", 32'(opb_req_valid), 32'h1);
            check("R11 held address", opb_req_addr, a);
        end
        opb_req_ready = 1'b1;
        @(negedge clk);
        opb_req_ready = 1'b0;
        if (probe != 0) begin
            apb_rd(12'h004, v);
            check("R10 busy bit", v, 32'h8000_0000);
            apb_wr(12'h004, 32'h0);
        end
        opb_rsp_valid = 1'b1;
        opb_rsp_err   = (err != 0);
        opb_rsp_rdata = rsp;
        @(negedge clk);
        opb_rsp_valid = 1'b0;
        opb_rsp_err   = 1'b0;
        if (probe != 0) begin
            for (int i = 0; i < 4; i++) begin
                check("R10 trigger while busy ignored", 32'(opb_req_valid), 32'h0);
                @(negedge clk);
            end
        end
        apb_rd(12'h048, v);
        check(err ? "R9 status unchanged" : "R8 status set", v, err ? 32'h0 : 32'(1 << (16 + c)));
        check(err ? "R9 irq low" : "R8 irq high", 32'(irq), err ? 32'h0 : 32'h1);
        if (rd != 0 && err == 0) exp_cap[c] = exp_rd;
        apb_rd(capa(c), v);
        check(err ? "R9 capture kept" : "R7 capture", v, exp_cap[c]);
        if (err == 0) begin
            apb_wr(12'h048, 32'(1 << (17 - c)));
            apb_rd(12'h048, v);
            check("R8 other bit clear keeps flag", v, 32'(1 << (16 + c)));
            apb_wr(12'h048, 32'(1 << (16 + c)));
            apb_rd(12'h048, v);
            check("R8 write-one clears", v, 32'h0);
            check("R8 irq cleared", 32'(irq), 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL all requirements: watchdog actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        exp_cap[0] = '0;
        exp_cap[1] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq after reset", 32'(irq), 32'h0);
        check("R11 no request after reset", 32'(opb_req_valid), 32'h0);
        check("R12 apb ready", 32'(apb_ready), 32'h1);

        // R1 reset values
        apb_rd(12'h000, v); check("R1 version", v, 32'h0000_00A1);
        apb_rd(12'h04C, v); check("R1 ch0 write word endian", v, 32'h0044_EEE4);
        apb_rd(12'h050, v); check("R1 ch0 write byte endian", v, 32'h0055_AAFF);
        apb_rd(12'h054, v); check("R1 ch1 write word endian", v, 32'h0011_7717);
        apb_rd(12'h058, v); check("R1 ch1 write byte endian", v, 32'hFFAA_5500);
        apb_rd(12'h05C, v); check("R1 ch0 read byte endian", v, 32'h0044_EEE4);
        apb_rd(12'h060, v); check("R1 ch1 read byte endian", v, 32'h0011_7717);
        for (int a = 12'h004; a <= 12'h048; a += 4) begin
            if (a >= 12'h010) begin
                apb_rd(12'(a), v); check("R1 zero reset", v, 32'h0);
            end
        end
        apb_rd(12'h084, v); check("R1 capture 0 reset", v, 32'h0);
        apb_rd(12'h090, v); check("R1 capture 1 reset", v, 32'h0);

        // R2 storage and ignored accesses
        apb_wr(12'h008, 32'hDEAD_BEEF); apb_rd(12'h008, v); check("R2 control", v, 32'hDEAD_BEEF);
        apb_wr(12'h00C, 32'hA000_0000); apb_rd(12'h00C, v); check("R2 window", v, 32'hA000_0000);
        for (int c = 0; c < 2; c++) begin
            apb_wr(12'(12'h04C + c * 8), 32'h0011_101B + 32'(c));
            apb_rd(12'(12'h04C + c * 8), v); check("R2 write word endian", v, 32'h0011_101B + 32'(c));
            apb_wr(12'(12'h050 + c * 8), 32'h0C33_0F3F + 32'(c));
            apb_rd(12'(12'h050 + c * 8), v); check("R2 write byte endian", v, 32'h0C33_0F3F + 32'(c));
            apb_wr(12'(12'h05C + c * 4), 32'h0003_0B1B + 32'(c));
            apb_rd(12'(12'h05C + c * 4), v); check("R2 read byte endian", v, 32'h0003_0B1B + 32'(c));
            apb_wr(chb(c) + 12'hC, 32'h1357_9BDF);
            apb_rd(chb(c) + 12'hC, v); check("R2 channel address", v, 32'h1357_9BDF);
        end
        apb_wr(12'h000, 32'h0); apb_rd(12'h000, v); check("R2 version read-only", v, 32'h0000_00A1);
        apb_wr(12'h084, 32'hFFFF_FFFF); apb_rd(12'h084, v); check("R2 capture read-only", v, 32'h0);
        apb_wr(12'h024, 32'hFFFF_FFFF); apb_rd(12'h024, v); check("R2 hole reads zero", v, 32'h0);
        apb_wr(12'h100, 32'hFFFF_FFFF); apb_rd(12'h100, v); check("R2 beyond range", v, 32'h0);
        apb_rd(12'hFFC, v); check("R2 top of window", v, 32'h0);
        apb_wr(12'h009, 32'h0); apb_rd(12'h008, v); check("R2 unaligned write ignored", v, 32'hDEAD_BEEF);

        // R4 and R5 rejected launches
        expect_no_launch("R4 neither selected", 0, 32'h3);
        expect_no_launch("R4 both selected", 3, 32'h3);
        expect_no_launch("R5 size code 2", 1, 32'h2);
        expect_no_launch("R5 size high bit", 1, 32'h10);

        // Main sweep: channel x direction x size x low address
        for (int c = 0; c < 2; c++)
            for (int rd = 0; rd < 2; rd++)
                for (int s = 0; s < 3; s++)
                    for (int lo = 0; lo < 4; lo++)
                        run_xact(c, rd, (s == 2) ? 3 : s, lo, 0, lo, 0);

        // R10 busy bit and retrigger, R9 error completions
        run_xact(0, 1, 3, 0, 0, 1, 1);
        run_xact(1, 1, 0, 2, 1, 0, 0);
        run_xact(0, 1, 1, 2, 1, 2, 0);
        run_xact(1, 0, 3, 0, 1, 0, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule